// File: doc/BRIEF.md
# Beam Weight Table Stepper

This controller drives the fast beam-switching strobes of a phased array whose antenna weight vectors sit in a table inside the array. Three strobe lines act on that table's pointer. One advances it by one entry. One clears the stepping logic back to the start. One returns the pointer to entry zero, the home entry. Upstream logic never toggles these lines itself. It raises a one-cycle command, and the controller produces the whole timed pulse train.

Four commands exist: a full reset of the stepping logic, a return to home, a step of N entries, and an autonomous sweep across the whole table with a programmable dwell time on each beam. While a train runs, `busy` is high. A one-cycle `done` marks its end. A local copy of the table pointer is kept on `beam_idx` so that upstream logic knows which beam is active. Strobe width and the minimum low gap are fixed at build time in clock cycles.

Top module: `bwt_stepper`

## Requirements
- R1: At most one of `strobe_inc`, `strobe_rst` and `strobe_home` is high in any cycle, and none is high while `busy` is low.
- R2: Every strobe stays high for exactly PULSE_W cycles. The only exception is a strobe cut short by a reset command. After every strobe falls, all strobes stay low for at least GAP_W cycles.
- R3: `busy` rises in the cycle after an accepted command and stays high until the last low gap of the train ends. `done` is high for exactly that following cycle, and `busy` is low in that cycle.
- R4: A step command with `step_count` = N > 0 emits exactly N increment strobes, each followed by GAP_W low cycles. With N = 0 it raises `done` in the next cycle and `busy` stays low.
- R5: A home command emits one `strobe_home` pulse followed by GAP_W low cycles, and leaves `beam_idx` at 0.
- R6: A reset command keeps all strobes low for GAP_W cycles, then emits one `strobe_rst` pulse and GAP_W low cycles, and leaves `beam_idx` at 0. It is accepted even while `busy` is high. It then aborts the running train at once, drops that train's `done`, and a strobe cut short by it does not move `beam_idx`.
- R7: A sweep command latches `dwell`. It emits one home pulse, then TABLE_DEPTH-1 increment pulses each followed by GAP_W+`dwell` low cycles, then one final home pulse. It ends with `beam_idx` at 0.
- R8: `beam_idx` changes only at the clock edge where a strobe falls after its full width. An increment pulse adds one modulo TABLE_DEPTH. A home or reset pulse sets it to 0.
- R9: Home, step and sweep commands that arrive while `busy` is high are ignored. When several commands arrive in the same cycle, the priority is reset, then home, then sweep, then step.
- R10: While `rst_n` is low, all strobes, `busy` and `done` are low and `beam_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | One-cycle reset command |
| cmd_home | input | 1 | One-cycle return-to-home command |
| cmd_step | input | 1 | One-cycle step command |
| step_count | input | N_W | Number of steps, sampled with `cmd_step` |
| cmd_sweep | input | 1 | One-cycle sweep command |
| dwell | input | DWELL_W | Extra low cycles after each sweep increment, sampled with `cmd_sweep` |
| strobe_inc | output | 1 | Table advance strobe |
| strobe_rst | output | 1 | Stepping-logic reset strobe |
| strobe_home | output | 1 | Return-to-entry-zero strobe |
| beam_idx | output | $clog2(TABLE_DEPTH) | Current table entry |
| busy | output | 1 | A pulse train is running |
| done | output | 1 | One-cycle end-of-train marker |

## Verification
The assertions assume that each command line is a single-cycle pulse sampled on a rising edge. They also assume that `step_count` and `dwell` are valid in the cycle their command is high, and that PULSE_W and GAP_W are at least one. The pulse-width property excludes a strobe whose fall follows a sampled reset command, because that fall is an intended abort. The stimulus raises each command for exactly one cycle at the falling edge and holds the data inputs stable around it. It sends reset commands at a spread of offsets into running trains, so that aborts land in leading gaps, in strobes and in trailing gaps.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_PULSE, PH_GAP} phase_e;
  typedef enum logic [1:0] {SEL_INC, SEL_RST, SEL_HOME} sel_e;
  typedef enum logic [1:0] {OP_RESET, OP_HOME, OP_STEP, OP_SWEEP} op_e;
endpackage

// File: rtl/bwt_timer.sv
module bwt_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bwt_index.sv
module bwt_index #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx;
    if (clr)
      idx_d = '0;
    else if (adv)
      idx_d = (idx == LAST) ? '0 : idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_d;
  end
endmodule

// File: rtl/bwt_seq.sv
module bwt_seq
  import bwt_pkg::*;
#(
  parameter int TABLE_DEPTH = 8,
  parameter int PULSE_W     = 2,
  parameter int GAP_W       = 3,
  parameter int N_W         = 8,
  parameter int DWELL_W     = 8,
  parameter int TMR_W       = DWELL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_reset,
  input  logic               cmd_home,
  input  logic               cmd_step,
  input  logic [N_W-1:0]     step_count,
  input  logic               cmd_sweep,
  input  logic [DWELL_W-1:0] dwell,
  input  logic               expired,
  output phase_e             ph,
  output sel_e               sel,
  output logic               tmr_load,
  output logic [TMR_W-1:0]   tmr_val,
  output logic               idx_adv,
  output logic               idx_clr,
  output logic               done
);
  localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_W - 1);
  localparam logic [TMR_W-1:0] GAP_LD   = TMR_W'(GAP_W - 1);

  phase_e             ph_d;
  sel_e               sel_d;
  op_e                op_q, op_d;
  logic [N_W-1:0]     rem_q, rem_d;
  logic               fin_q, fin_d;
  logic [DWELL_W-1:0] dw_q, dw_d;
  logic               done_d;

  always_comb begin
    ph_d = ph; sel_d = sel; op_d = op_q; rem_d = rem_q;
    fin_d = fin_q; dw_d = dw_q; done_d = 1'b0;
    tmr_load = 1'b0; tmr_val = '0; idx_adv = 1'b0; idx_clr = 1'b0;
    if (cmd_reset) begin
      ph_d = PH_LEAD; op_d = OP_RESET; tmr_load = 1'b1; tmr_val = GAP_LD;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (cmd_home) begin
            ph_d = PH_PULSE; sel_d = SEL_HOME; op_d = OP_HOME;
            tmr_load = 1'b1; tmr_val = PULSE_LD;
          end else if (cmd_sweep) begin
            ph_d = PH_PULSE; sel_d = SEL_HOME; op_d = OP_SWEEP; fin_d = 1'b0;
            rem_d = N_W'(TABLE_DEPTH - 1); dw_d = dwell;
            tmr_load = 1'b1; tmr_val = PULSE_LD;
          end else if (cmd_step) begin
            if (step_count == '0) begin
              done_d = 1'b1;
            end else begin
              ph_d = PH_PULSE; sel_d = SEL_INC; op_d = OP_STEP; rem_d = step_count;
              tmr_load = 1'b1; tmr_val = PULSE_LD;
            end
          end
        end
        PH_LEAD: begin
          if (expired) begin
            ph_d = PH_PULSE; sel_d = SEL_RST; tmr_load = 1'b1; tmr_val = PULSE_LD;
          end
        end
        PH_PULSE: begin
          if (expired) begin
            ph_d = PH_GAP; tmr_load = 1'b1; tmr_val = GAP_LD;
            if (sel == SEL_INC) begin
              idx_adv = 1'b1;
              rem_d   = rem_q - N_W'(1);
              if (op_q == OP_SWEEP) tmr_val = GAP_LD + TMR_W'(dw_q);
            end else begin
              idx_clr = 1'b1;
            end
          end
        end
        PH_GAP: begin
          if (expired) begin
            if (op_q == OP_RESET || op_q == OP_HOME ||
                (op_q == OP_STEP && rem_q == '0) || (op_q == OP_SWEEP && fin_q)) begin
              ph_d = PH_IDLE; done_d = 1'b1;
            end else if (op_q == OP_SWEEP && rem_q == '0) begin
              ph_d = PH_PULSE; sel_d = SEL_HOME; fin_d = 1'b1;
              tmr_load = 1'b1; tmr_val = PULSE_LD;
            end else begin
              ph_d = PH_PULSE; sel_d = SEL_INC;
              tmr_load = 1'b1; tmr_val = PULSE_LD;
            end
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; sel <= SEL_INC; op_q <= OP_RESET; rem_q <= '0;
      fin_q <= 1'b0; dw_q <= '0; done <= 1'b0;
    end else begin
      ph <= ph_d; sel <= sel_d; op_q <= op_d; rem_q <= rem_d;
      fin_q <= fin_d; dw_q <= dw_d; done <= done_d;
    end
  end
endmodule

// File: rtl/bwt_stepper.sv
module bwt_stepper
  import bwt_pkg::*;
#(
  parameter int TABLE_DEPTH = 8,
  parameter int PULSE_W     = 2,
  parameter int GAP_W       = 3,
  parameter int N_W         = 8,
  parameter int DWELL_W     = 8,
  localparam int IDX_W      = $clog2(TABLE_DEPTH),
  localparam int TMR_W      = DWELL_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_reset,
  input  logic               cmd_home,
  input  logic               cmd_step,
  input  logic [N_W-1:0]     step_count,
  input  logic               cmd_sweep,
  input  logic [DWELL_W-1:0] dwell,
  output logic               strobe_inc,
  output logic               strobe_rst,
  output logic               strobe_home,
  output logic [IDX_W-1:0]   beam_idx,
  output logic               busy,
  output logic               done
);
  phase_e           ph;
  sel_e             sel;
  logic             expired, tmr_load, idx_adv, idx_clr;
  logic [TMR_W-1:0] tmr_val;
  logic [2:0]       strb;

  bwt_seq #(
    .TABLE_DEPTH(TABLE_DEPTH), .PULSE_W(PULSE_W), .GAP_W(GAP_W),
    .N_W(N_W), .DWELL_W(DWELL_W), .TMR_W(TMR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_home(cmd_home),
    .cmd_step(cmd_step), .step_count(step_count), .cmd_sweep(cmd_sweep),
    .dwell(dwell), .expired(expired), .ph(ph), .sel(sel),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .idx_adv(idx_adv),
    .idx_clr(idx_clr), .done(done)
  );

  bwt_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
  );

  bwt_index #(.DEPTH(TABLE_DEPTH), .IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .adv(idx_adv), .clr(idx_clr), .idx(beam_idx)
  );

  for (genvar g = 0; g < 3; g++) begin : g_strobe
    assign strb[g] = (ph == PH_PULSE) && (2'(sel) == 2'(g));
  end

  assign strobe_inc  = strb[0];
  assign strobe_rst  = strb[1];
  assign strobe_home = strb[2];
  assign busy        = (ph != PH_IDLE);
endmodule

// File: rtl/bwt_stepper_chk.sv
module bwt_stepper_chk #(
  parameter int TABLE_DEPTH = 8,
  parameter int PULSE_W     = 2,
  parameter int GAP_W       = 3,
  parameter int N_W         = 8,
  localparam int IDX_W      = $clog2(TABLE_DEPTH),
  localparam int CW         = $clog2(PULSE_W + GAP_W + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_reset,
  input logic             cmd_home,
  input logic             cmd_step,
  input logic [N_W-1:0]   step_count,
  input logic             cmd_sweep,
  input logic             strobe_inc,
  input logic             strobe_rst,
  input logic             strobe_home,
  input logic [IDX_W-1:0] beam_idx,
  input logic             busy,
  input logic             done
);
  logic          any_stb;
  logic [CW-1:0] hi_cnt, lo_cnt;

  assign any_stb = strobe_inc | strobe_rst | strobe_home;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= CW'(GAP_W);
    end else if (any_stb) begin
      hi_cnt <= (hi_cnt > CW'(PULSE_W)) ? hi_cnt : hi_cnt + CW'(1);
      lo_cnt <= '0;
    end else begin
      hi_cnt <= '0;
      lo_cnt <= (lo_cnt >= CW'(GAP_W)) ? lo_cnt : lo_cnt + CW'(1);
    end
  end

  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe_inc, strobe_rst, strobe_home}));

  assert_strobe_needs_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> busy);

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stb && $past(any_stb) && !$past(cmd_reset)) |-> hi_cnt == CW'(PULSE_W));

  assert_gap_before_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && !$past(any_stb)) |-> lo_cnt >= CW'(GAP_W));

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_zero_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_step && step_count == '0 && !cmd_reset && !cmd_home && !cmd_sweep)
      |=> (done && !busy));

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beam_idx <= IDX_W'(TABLE_DEPTH - 1));

  assert_idx_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_idx != $past(beam_idx)) |-> ($past(any_stb) && !any_stb));

  assert_rst_pulse_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strobe_rst) && !$past(cmd_reset)) |-> beam_idx == '0);

  assert_idle_stays_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_reset && !cmd_home && !cmd_step && !cmd_sweep) |=> !busy);
endmodule

bind bwt_stepper bwt_stepper_chk #(
  .TABLE_DEPTH(TABLE_DEPTH), .PULSE_W(PULSE_W), .GAP_W(GAP_W), .N_W(N_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_home(cmd_home),
  .cmd_step(cmd_step), .step_count(step_count), .cmd_sweep(cmd_sweep),
  .strobe_inc(strobe_inc), .strobe_rst(strobe_rst), .strobe_home(strobe_home),
  .beam_idx(beam_idx), .busy(busy), .done(done)
);

// File: tb/bwt_stepper_test.sv
module bwt_stepper_test;
  localparam int D  = 8;
  localparam int PW = 2;
  localparam int GW = 3;
  localparam int NW = 8;
  localparam int DW = 8;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_rst = 1'b0, c_home = 1'b0, c_step = 1'b0, c_sweep = 1'b0;
  logic [NW-1:0] s_cnt = '0;
  logic [DW-1:0] dwl = '0;
  logic s_inc, s_rst, s_home, busy, done;
  logic [IW-1:0] bidx;

  always #4 clk = ~clk;

  bwt_stepper #(.TABLE_DEPTH(D), .PULSE_W(PW), .GAP_W(GW), .N_W(NW), .DWELL_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_reset(c_rst), .cmd_home(c_home),
    .cmd_step(c_step), .step_count(s_cnt), .cmd_sweep(c_sweep), .dwell(dwl),
    .strobe_inc(s_inc), .strobe_rst(s_rst), .strobe_home(s_home),
    .beam_idx(bidx), .busy(busy), .done(done)
  );

  // Reference model: expected outputs per cycle kept in a queue.
  // Strobe bit 0 = increment, bit 1 = reset, bit 2 = home.
  typedef struct { bit [2:0] stb; int idx; bit bz; bit dn; } ent_t;
  ent_t q[$];
  ent_t cur = '{3'b000, 0, 1'b0, 1'b0};
  int vectors = 0, miscompares = 0, cycles = 0;
  string req = "R10";
  bit finished = 1'b0;

  task automatic add(bit [2:0] s, int i, bit bz, bit dn);
    ent_t e;
    e.stb = s; e.idx = i; e.bz = bz; e.dn = dn;
    q.push_back(e);
  endtask

  task automatic pulse(bit [2:0] s, int gap, inout int b, input int nb);
    repeat (PW) add(s, b, 1'b1, 1'b0);
    b = nb;
    repeat (gap) add(3'b000, b, 1'b1, 1'b0);
  endtask

  always @(posedge clk) begin
    int b;
    cycles++;
    if (!rst_n) begin
      q.delete();
      cur = '{3'b000, 0, 1'b0, 1'b0};
    end else begin
      b = cur.idx;
      if (c_rst) begin
        q.delete();
        repeat (GW) add(3'b000, b, 1'b1, 1'b0);
        pulse(3'b010, GW, b, 0);
        add(3'b000, b, 1'b0, 1'b1);
      end else if (!cur.bz) begin
        if (c_home) begin
          pulse(3'b100, GW, b, 0);
          add(3'b000, b, 1'b0, 1'b1);
        end else if (c_sweep) begin
          pulse(3'b100, GW, b, 0);
          for (int k = 0; k < D - 1; k++) pulse(3'b001, GW + int'(dwl), b, (b + 1) % D);
          pulse(3'b100, GW, b, 0);
          add(3'b000, b, 1'b0, 1'b1);
        end else if (c_step) begin
          for (int k = 0; k < int'(s_cnt); k++) pulse(3'b001, GW, b, (b + 1) % D);
          add(3'b000, b, 1'b0, 1'b1);
        end
      end
      if (q.size() != 0) cur = q.pop_front();
      else cur = '{3'b000, cur.idx, 1'b0, 1'b0};
    end
    if (cycles > 150000 && !finished) begin
      miscompares++;
      $display("FAIL watchdog: run still going after %0d cycles, expected end", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      finished = 1'b1;
      $finish;
    end
  end

  always @(negedge clk) begin
    bit [2:0] got;
    got = {s_home, s_rst, s_inc};
    vectors++;
    if (got !== cur.stb || int'(bidx) != cur.idx || busy !== cur.bz || done !== cur.dn) begin
      miscompares++;
      $display("FAIL %s t=%0t: stb=%b idx=%0d busy=%b done=%b expected stb=%b idx=%0d busy=%b done=%b",
               req, $time, got, bidx, busy, done, cur.stb, cur.idx, cur.bz, cur.dn);
    end
    vectors++;
    if ($countones(got) > 1 || (got != 3'b000 && !busy)) begin
      miscompares++;
      $display("FAIL R1 t=%0t: stb=%b busy=%b expected one-hot strobe under busy", $time, got, busy);
    end
  end

  task automatic fire(bit r, bit h, bit sw, bit st, int n, int dw);
    c_rst = r; c_home = h; c_sweep = sw; c_step = st;
    s_cnt = NW'(n); dwl = DW'(dw);
    @(negedge clk);
    c_rst = 1'b0; c_home = 1'b0; c_sweep = 1'b0; c_step = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0 || cur.bz) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    req = "R10";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    req = "R4"; fire(0, 0, 0, 1, 3, 0); wait_idle();
    req = "R4"; fire(0, 0, 0, 1, 0, 0); wait_idle();
    req = "R5"; fire(0, 1, 0, 0, 0, 0); wait_idle();
    req = "R8"; fire(0, 0, 0, 1, D + 3, 0); wait_idle();
    req = "R2"; fire(0, 0, 0, 1, 2, 0); wait_idle();
    req = "R7"; fire(0, 0, 1, 0, 0, 3); wait_idle();
    req = "R1"; fire(0, 0, 1, 0, 0, 0); wait_idle();
    req = "R9";
    fire(0, 0, 0, 1, 5, 0);
    repeat (3) @(negedge clk);
    fire(0, 1, 0, 0, 0, 0);
    fire(0, 0, 1, 0, 0, 2);
    repeat (4) @(negedge clk);
    fire(0, 0, 0, 1, 1, 0);
    wait_idle();
    req = "R9"; fire(0, 1, 0, 1, 4, 0); wait_idle();
    req = "R9"; fire(0, 0, 1, 1, 2, 1); wait_idle();
    req = "R3"; fire(0, 0, 0, 1, 1, 0); fire(0, 0, 0, 1, 1, 0); wait_idle();
    for (int off = 0; off < 10; off++) begin
      req = "R6";
      fire(0, 0, 0, 1, 1, 0);
      fire(0, 0, 0, 1, 4, 0);
      repeat (off) @(negedge clk);
      fire(1, 0, 0, 0, 0, 0);
      wait_idle();
    end
    req = "R6"; fire(0, 0, 1, 0, 0, 1); repeat (7) @(negedge clk);
    fire(1, 1, 0, 1, 3, 0); repeat (2) @(negedge clk);
    fire(1, 0, 0, 0, 0, 0); wait_idle();
    req = "R10";
    fire(0, 0, 0, 1, 3, 0); repeat (3) @(negedge clk);
    rst_n = 1'b0; repeat (3) @(negedge clk);
    rst_n = 1'b1; repeat (3) @(negedge clk);
    if (!finished) begin
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      finished = 1'b1;
      $finish;
    end
  end
endmodule